// File: doc/BRIEF.md
# Two-Way Set-Associative Read Cache Lookup

This block is the lookup and refill path of a read-only cache with two ways per set. A single request carries a byte address. The block splits the address into a tag, a set index and a word select. It reads the tag and line of both ways of the selected set at once and compares both tags in parallel. When one way holds a valid matching tag, that way's line is selected and the addressed 32-bit word is returned with a hit flag.

When neither way matches, the block issues one line-aligned fill request to the next level and waits for the 128-bit line to come back. The line is installed in an invalid way if the set has one. Otherwise it replaces the least recently used way, which is tracked by a single bit per set. The requested word is returned from the incoming line with the hit flag low. The default geometry is 32 KB of storage in 16-byte lines, which gives 1024 sets and an 18-bit tag for a 32-bit address. The block serves one request at a time.

Top module: `tsa_cache_lookup`

## Requirements
- R1: The address splits into a tag in bits 31..14, a set index in bits 13..4, a word select in bits 3..2, and a byte offset in bits 1..0. The byte offset has no effect on the hit flag or on the returned word.
- R2: A request hits when either way of the indexed set is valid and holds the address tag. A hit returns `rsp_hit`=1 and raises no fill request.
- R3: The returned word is bits [32*w+31 : 32*w] of the selected 128-bit line, where w is the word select.
- R4: A miss raises `fill_req_valid` for exactly one cycle. `fill_req_addr` equals the request address with bits 3..0 cleared.
- R5: The line on `fill_rsp_line` is taken only while a fill is outstanding. Taking it installs the line and returns the addressed word from it with `rsp_hit`=0. A fill response that arrives while no fill is outstanding changes nothing.
- R6: If a way of the indexed set is invalid, a fill goes into an invalid way, with way 0 tried first. No valid line is evicted in that case.
- R7: When both ways are valid, a fill replaces the least recently used way. Every hit and every fill marks the other way of that set as least recently used.
- R8: Two ways of one set never hold the same valid tag.
- R9: Reset invalidates every line, raises `req_ready`, and holds `rsp_valid` and `fill_req_valid` low.
- R10: `req_ready` falls in the cycle after a request is accepted and stays low until the response has been given. `rsp_valid` is a single-cycle pulse. A hit is answered in the second cycle after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_addr | input | 32 | Byte address of the requested word |
| req_ready | output | 1 | Block is idle and takes a request this cycle |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_hit | output | 1 | Response was served from the cache |
| rsp_data | output | 32 | Requested word |
| fill_req_valid | output | 1 | One-cycle line request to the next level |
| fill_req_addr | output | 32 | Line-aligned address of the line requested |
| fill_rsp_valid | input | 1 | Next level returns the requested line |
| fill_rsp_line | input | 128 | Returned line, lowest-addressed word in the low bits |

## Verification
The main sequence works inside one set with three tags. Two tags land in the two empty ways, which separates invalid-first placement from LRU placement. Then a recently hit line is kept while its partner is evicted, which shows that the LRU bit follows hits as well as fills. Further steps show that the second eviction picks the opposite way. A neighbouring set and a tag that differs only in its top bit show that the index and the full tag width both take part in the lookup. Odd byte offsets and all four word selects show the word mux and that the byte bits are ignored. A stray fill response, and a reset after the cache has been filled, show that lines are installed only on real misses and that reset clears them.

// File: rtl/tsa_cache_pkg.sv
package tsa_cache_pkg;

    localparam int unsigned NUM_WAYS = 2;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOOK = 2'd1,
        ST_WAIT = 2'd2
    } lkp_state_e;

endpackage

// File: rtl/tsa_way_store.sv
module tsa_way_store #(
    parameter int unsigned SETS   = 1024,
    parameter int unsigned IDX_W  = 10,
    parameter int unsigned TAG_W  = 18,
    parameter int unsigned LINE_W = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  idx,
    input  logic [TAG_W-1:0]  tag,
    input  logic              wr_en,
    input  logic [LINE_W-1:0] wr_line,
    output logic              match,
    output logic              valid,
    output logic [LINE_W-1:0] line
);

    logic [SETS-1:0]   valid_d, valid_q;
    logic [TAG_W-1:0]  tag_mem  [SETS];
    logic [LINE_W-1:0] line_mem [SETS];

    always_comb begin
        valid_d = valid_q;
        if (wr_en) begin
            valid_d[idx] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q <= '0;
        end else begin
            valid_q <= valid_d;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_mem[idx]  <= tag;
            line_mem[idx] <= wr_line;
        end
    end

    assign valid = valid_q[idx];
    assign line  = line_mem[idx];
    assign match = valid && (tag_mem[idx] == tag);

endmodule

// File: rtl/tsa_lru_bits.sv
module tsa_lru_bits #(
    parameter int unsigned SETS  = 1024,
    parameter int unsigned IDX_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] idx,
    input  logic             upd_en,
    input  logic             upd_lru_way,
    output logic             lru_way
);

    logic [SETS-1:0] lru_d, lru_q;

    always_comb begin
        lru_d = lru_q;
        if (upd_en) begin
            lru_d[idx] = upd_lru_way;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lru_q <= '0;
        end else begin
            lru_q <= lru_d;
        end
    end

    assign lru_way = lru_q[idx];

endmodule

// File: rtl/tsa_victim_pick.sv
module tsa_victim_pick
    import tsa_cache_pkg::*;
(
    input  logic [NUM_WAYS-1:0] way_valid,
    input  logic                lru_way,
    output logic                victim
);

    always_comb begin
        if (!way_valid[0]) begin
            victim = 1'b0;
        end else if (!way_valid[1]) begin
            victim = 1'b1;
        end else begin
            victim = lru_way;
        end
    end

endmodule

// File: rtl/tsa_cache_lookup.sv
module tsa_cache_lookup
    import tsa_cache_pkg::*;
#(
    parameter int unsigned ADDR_W      = 32,
    parameter int unsigned WORD_W      = 32,
    parameter int unsigned LINE_BYTES  = 16,
    parameter int unsigned CACHE_BYTES = 32768
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_valid,
    input  logic [ADDR_W-1:0]        req_addr,
    output logic                     req_ready,
    output logic                     rsp_valid,
    output logic                     rsp_hit,
    output logic [WORD_W-1:0]        rsp_data,
    output logic                     fill_req_valid,
    output logic [ADDR_W-1:0]        fill_req_addr,
    input  logic                     fill_rsp_valid,
    input  logic [LINE_BYTES*8-1:0]  fill_rsp_line
);

    localparam int unsigned LINE_W = LINE_BYTES * 8;
    localparam int unsigned OFF_W  = $clog2(LINE_BYTES);
    localparam int unsigned SETS   = CACHE_BYTES / LINE_BYTES / NUM_WAYS;
    localparam int unsigned IDX_W  = $clog2(SETS);
    localparam int unsigned TAG_W  = ADDR_W - IDX_W - OFF_W;
    localparam int unsigned WPL    = LINE_W / WORD_W;
    localparam int unsigned WSEL_W = $clog2(WPL);
    localparam int unsigned BYTE_W = OFF_W - WSEL_W;

    typedef struct packed {
        lkp_state_e          state;
        logic [ADDR_W-1:0]   addr;
        logic                victim;
        logic                rsp_valid;
        logic                rsp_hit;
        logic [WORD_W-1:0]   rsp_data;
        logic                fill_req;
    } ctrl_t;

    ctrl_t ctrl_d, ctrl_q;

    logic [TAG_W-1:0]  cur_tag;
    logic [IDX_W-1:0]  cur_idx;
    logic [WSEL_W-1:0] cur_wsel;

    assign cur_tag  = ctrl_q.addr[ADDR_W-1 -: TAG_W];
    assign cur_idx  = ctrl_q.addr[OFF_W +: IDX_W];
    assign cur_wsel = ctrl_q.addr[BYTE_W +: WSEL_W];

    logic [NUM_WAYS-1:0] way_match;
    logic [NUM_WAYS-1:0] way_valid;
    logic [NUM_WAYS-1:0] way_we;
    logic [LINE_W-1:0]   way_line [NUM_WAYS];

    for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
        tsa_way_store #(
            .SETS   (SETS),
            .IDX_W  (IDX_W),
            .TAG_W  (TAG_W),
            .LINE_W (LINE_W)
        ) u_store (
            .clk     (clk),
            .rst_n   (rst_n),
            .idx     (cur_idx),
            .tag     (cur_tag),
            .wr_en   (way_we[w]),
            .wr_line (fill_rsp_line),
            .match   (way_match[w]),
            .valid   (way_valid[w]),
            .line    (way_line[w])
        );
    end

    logic lru_way, lru_we, lru_new, victim_sel;

    tsa_lru_bits #(
        .SETS  (SETS),
        .IDX_W (IDX_W)
    ) u_lru (
        .clk         (clk),
        .rst_n       (rst_n),
        .idx         (cur_idx),
        .upd_en      (lru_we),
        .upd_lru_way (lru_new),
        .lru_way     (lru_way)
    );

    tsa_victim_pick u_victim (
        .way_valid (way_valid),
        .lru_way   (lru_way),
        .victim    (victim_sel)
    );

    // Output mux steered by the matching way
    logic              hit_any;
    logic              hit_way;
    logic [LINE_W-1:0] hit_line;

    always_comb begin
        hit_way  = 1'b0;
        hit_line = '0;
        for (int w = 0; w < NUM_WAYS; w++) begin
            if (way_match[w]) begin
                hit_way  = w[0];
                hit_line = way_line[w];
            end
        end
    end

    assign hit_any = |way_match;

    always_comb begin
        ctrl_d           = ctrl_q;
        ctrl_d.rsp_valid = 1'b0;
        ctrl_d.fill_req  = 1'b0;
        way_we           = '0;
        lru_we           = 1'b0;
        lru_new          = 1'b0;
        case (ctrl_q.state)
            ST_IDLE: begin
                if (req_valid) begin
                    ctrl_d.addr  = req_addr;
                    ctrl_d.state = ST_LOOK;
                end
            end
            ST_LOOK: begin
                if (hit_any) begin
                    ctrl_d.rsp_valid = 1'b1;
                    ctrl_d.rsp_hit   = 1'b1;
                    ctrl_d.rsp_data  = hit_line[cur_wsel*WORD_W +: WORD_W];
                    lru_we           = 1'b1;
                    lru_new          = ~hit_way;
                    ctrl_d.state     = ST_IDLE;
                end else begin
                    ctrl_d.victim    = victim_sel;
                    ctrl_d.fill_req  = 1'b1;
                    ctrl_d.state     = ST_WAIT;
                end
            end
            ST_WAIT: begin
                if (fill_rsp_valid) begin
                    way_we[ctrl_q.victim] = 1'b1;
                    lru_we           = 1'b1;
                    lru_new          = ~ctrl_q.victim;
                    ctrl_d.rsp_valid = 1'b1;
                    ctrl_d.rsp_hit   = 1'b0;
                    ctrl_d.rsp_data  = fill_rsp_line[cur_wsel*WORD_W +: WORD_W];
                    ctrl_d.state     = ST_IDLE;
                end
            end
            default: ctrl_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '{state: ST_IDLE, default: '0};
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    assign req_ready      = (ctrl_q.state == ST_IDLE);
    assign rsp_valid      = ctrl_q.rsp_valid;
    assign rsp_hit        = ctrl_q.rsp_hit;
    assign rsp_data       = ctrl_q.rsp_data;
    assign fill_req_valid = ctrl_q.fill_req;
    assign fill_req_addr  = {ctrl_q.addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};

endmodule

// File: rtl/tsa_cache_lookup_chk.sv
module tsa_cache_lookup_chk #(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned OFF_W  = 4,
    parameter int unsigned WAYS   = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic              rsp_hit,
    input logic              fill_req_valid,
    input logic [ADDR_W-1:0] fill_req_addr,
    input logic              fill_rsp_valid,
    input logic [WAYS-1:0]   way_match
);

    AST_SINGLE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(way_match)) else $error("two ways match"); // R8

    AST_FILL_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        fill_req_valid |-> (fill_req_addr[OFF_W-1:0] == '0)) else $error("fill unaligned"); // R4

    AST_FILL_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        fill_req_valid |=> !fill_req_valid) else $error("fill request held"); // R4

    AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready) else $error("ready after accept"); // R10

    AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid) else $error("response held"); // R10

    AST_MISS_FROM_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_hit) |-> $past(fill_rsp_valid)) else $error("miss without fill"); // R5

    AST_HIT_NO_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_hit) |-> !fill_req_valid) else $error("fill on hit"); // R2

endmodule

bind tsa_cache_lookup tsa_cache_lookup_chk #(
    .ADDR_W (ADDR_W),
    .OFF_W  (OFF_W),
    .WAYS   (tsa_cache_pkg::NUM_WAYS)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .req_valid      (req_valid),
    .req_ready      (req_ready),
    .rsp_valid      (rsp_valid),
    .rsp_hit        (rsp_hit),
    .fill_req_valid (fill_req_valid),
    .fill_req_addr  (fill_req_addr),
    .fill_rsp_valid (fill_rsp_valid),
    .way_match      (way_match)
);

// File: tb/tb_tsa_cache_lookup.sv
module tb_tsa_cache_lookup;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         req_valid = 1'b0;
    logic [31:0]  req_addr = '0;
    logic         req_ready;
    logic         rsp_valid;
    logic         rsp_hit;
    logic [31:0]  rsp_data;
    logic         fill_req_valid;
    logic [31:0]  fill_req_addr;
    logic         fill_rsp_valid = 1'b0;
    logic [127:0] fill_rsp_line = '0;

    int checks = 0;
    int fails  = 0;
    int fill_cnt = 0;
    logic [31:0] last_fill_addr = '0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    tsa_cache_lookup dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .req_valid      (req_valid),
        .req_addr       (req_addr),
        .req_ready      (req_ready),
        .rsp_valid      (rsp_valid),
        .rsp_hit        (rsp_hit),
        .rsp_data       (rsp_data),
        .fill_req_valid (fill_req_valid),
        .fill_req_addr  (fill_req_addr),
        .fill_rsp_valid (fill_rsp_valid),
        .fill_rsp_line  (fill_rsp_line)
    );

    function automatic logic [31:0] mem_word(input logic [31:0] a);
        return {a[31:2], 2'b00} ^ 32'h5A3C_96E1;
    endfunction

    function automatic logic [127:0] mem_line(input logic [31:0] a);
        logic [127:0] l;
        for (int i = 0; i < 4; i++) begin
            l[32*i +: 32] = mem_word({a[31:4], 4'h0} + 32'(4*i));
        end
        return l;
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Next-level responder: answers each fill request three cycles later
    initial begin
        forever begin
            @(negedge clk);
            if (fill_req_valid) begin
                fill_cnt++;
                last_fill_addr = fill_req_addr;
                repeat (3) @(negedge clk);
                fill_rsp_line  = mem_line(last_fill_addr);
                fill_rsp_valid = 1'b1;
                @(negedge clk);
                fill_rsp_valid = 1'b0;
            end
        end
    end

    // Issues one request and checks hit flag, data, fill traffic and latency
    task automatic access(input logic [31:0] a, input bit exp_hit, input string tag);
        int fills_before;
        int waited;
        fills_before = fill_cnt;
        check(req_ready === 1'b1, "R10 ready before request", 32'(req_ready), 32'd1);
        req_valid = 1'b1;
        req_addr  = a;
        @(negedge clk);
        req_valid = 1'b0;
        check(req_ready === 1'b0, "R10 busy after accept", 32'(req_ready), 32'd0);
        waited = 1;
        while (!rsp_valid && waited < 40) begin
            @(negedge clk);
            waited++;
        end
        check(rsp_valid === 1'b1, {tag, " response seen"}, 32'(rsp_valid), 32'd1);
        check(rsp_hit === exp_hit, {tag, " hit flag (R2/R6/R7)"}, 32'(rsp_hit), 32'(exp_hit));
        check(rsp_data === mem_word(a), {tag, " data word (R3/R5)"}, rsp_data, mem_word(a));
        if (exp_hit) begin
            check(waited == 2, "R10 hit latency", 32'(waited), 32'd2);
            check(fill_cnt == fills_before, "R2 no fill on hit", 32'(fill_cnt - fills_before), 32'd0);
        end else begin
            check(fill_cnt == fills_before + 1, "R4 one fill per miss", 32'(fill_cnt - fills_before), 32'd1);
            check(last_fill_addr === {a[31:4], 4'h0}, "R4 fill address", last_fill_addr, {a[31:4], 4'h0});
        end
        @(negedge clk);
        check(rsp_valid === 1'b0, "R10 response one cycle", 32'(rsp_valid), 32'd0);
    endtask

    // {address, expected hit}; set 5 unless noted, tags T1=0x00011 T2=0x00022 T3=0x20033
    localparam int NVEC = 14;
    localparam logic [32:0] VEC [NVEC] = '{
        {32'h0004_4050, 1'b0},  // T1 w0: cold miss, way0 (R6)
        {32'h0004_405C, 1'b1},  // T1 w3: same line (R3)
        {32'h0008_8054, 1'b0},  // T2: cold miss into empty way1 (R6)
        {32'h0004_4058, 1'b1},  // T1 still present (R6)
        {32'h800C_C050, 1'b0},  // T3 evicts LRU T2 (R7)
        {32'h0004_4054, 1'b1},  // T1 kept (R7)
        {32'h0008_8050, 1'b0},  // T2 gone, evicts T3
        {32'h800C_C05C, 1'b0},  // T3 evicts T1 (R7)
        {32'h0008_8058, 1'b1},  // T2 hit
        {32'h0004_4060, 1'b0},  // T1 in set 6 misses (R1)
        {32'h0004_406B, 1'b1},  // byte offset 3 ignored (R1)
        {32'h800C_C053, 1'b1},  // T3 with byte offset 3 (R1)
        {32'h8004_4050, 1'b0},  // tag differs only in bit 31 (R1)
        {32'h0008_8050, 1'b0}   // T2 evicted by previous fill (R7)
    };

    initial begin
        repeat (3) @(negedge clk);
        // R9 reset state
        check(req_ready === 1'b1, "R9 ready in reset", 32'(req_ready), 32'd1);
        check(rsp_valid === 1'b0, "R9 no response in reset", 32'(rsp_valid), 32'd0);
        check(fill_req_valid === 1'b0, "R9 no fill in reset", 32'(fill_req_valid), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NVEC; i++) begin
            access(VEC[i][32:1], VEC[i][0], $sformatf("vec%0d", i));
        end

        // R5: stray fill response with garbage while idle is ignored
        fill_rsp_line  = {4{32'hDEAD_BEEF}};
        fill_rsp_valid = 1'b1;
        @(negedge clk);
        fill_rsp_valid = 1'b0;
        check(rsp_valid === 1'b0, "R5 stray fill gives no response", 32'(rsp_valid), 32'd0);
        access(32'h0008_805C, 1'b1, "R5 stray fill left line intact");

        // R9: reset clears all lines
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        access(32'h0008_8050, 1'b0, "R9 line gone after reset");
        access(32'h0008_8054, 1'b1, "R9 refilled line hits");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 20000, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule